// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. A host reaches it through a plain 32-bit register port. Through that port it reads the synchronised pin levels and chooses the direction of each pin. It drives outputs through separate set and clear registers, so a change to one pin never needs a read-modify-write of its neighbours. Each pin also carries a 2-bit alternate-function selector. The selector is only exposed on a port, for pad muxing elsewhere.

Every pin has its own rising-edge and falling-edge enable. Each enabled transition latches a sticky status bit, and the host clears that bit by writing a one to it. Any pending status bit anywhere in the block raises one combined interrupt line. Registers are grouped by kind. Each group spans as many words as the pin count needs, so the address map stretches with the parameter.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NW = NPINS/32, register kind k (0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function) word w sits at byte address k*NW*4 + w*4. Pin p occupies bit p%32 of word p/32. The alternate-function group spans 2*NW words. Addresses beyond 9*NW words, or with bus_addr[1:0] nonzero, read as zero and ignore writes. Writes to the level group are ignored.
- R2: A read issued in one cycle returns its data on bus_rdata in the next cycle. A level read returns pin_in after a two-flop synchroniser.
- R3: Direction bit 1 makes the pin an output (pin_oe high), and 0 makes it an input. The register reads back as written.
- R4: Writing the set group drives pin_out high for every one bit and leaves zero bits unchanged. Reads of the set or the clear group return the output latch.
- R5: Writing the clear group drives pin_out low for every one bit and leaves zero bits unchanged.
- R6: With a pin's rising enable set, a low-to-high change of its synchronised input sets its status bit. The bit is visible three clock edges after pin_in changes.
- R7: With a pin's falling enable set, a high-to-low change sets its status bit. With both enables set, both directions flag.
- R8: A transition on a pin whose matching enable is clear leaves its status bit unchanged.
- R9: Status bits are sticky. Writing a one clears that bit, zero bits are unaffected, and an all-ones write clears the whole word.
- R10: If an enabled edge arrives in the same cycle as a clearing write to its bit, the bit stays set.
- R11: Pin p's alternate-function field is bits (p%16)*2+1:(p%16)*2 of alternate word p/16, and it appears on alt_sel[2p+1:2p].
- R12: irq is high exactly when at least one status bit in any word is set.
- R13: After reset every register is zero: all pins are inputs, pin_out is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Output data latch |
| pin_oe | output | NPINS | Output enable per pin (1 = drive) |
| alt_sel | output | 2*NPINS | Alternate-function field per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach is an enabled edge that lands in exactly the cycle in which the host writes a one to clear that same status bit. Only this cycle shows whether the event is kept or lost. The bench changes a pin on a falling clock edge, counts the two synchroniser edges, and times a clearing write so that its capture edge is the detection edge. In the same write it clears a second, older pending bit, which must go. Random pin patterns interleaved with random writes across every group, including unmapped addresses, then exercise the sticky status alongside the enables.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [2:0] {
      RK_LEVEL = 3'd0,
      RK_DIR   = 3'd1,
      RK_SET   = 3'd2,
      RK_CLR   = 3'd3,
      RK_RISE  = 3'd4,
      RK_FALL  = 3'd5,
      RK_STAT  = 3'd6,
      RK_ALT   = 3'd7
   } reg_kind_e;

   localparam int WORD_BITS    = 32;
   localparam int ALT_PER_WORD = 16;
   localparam int NUM_KINDS    = 8;

   function automatic int words_for_kind(input reg_kind_e k, input int nw);
      return (k == RK_ALT) ? 2 * nw : nw;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_bank_pkg::*;
#(
   parameter int NW     = 2,
   parameter int ADDR_W = 8,
   localparam int IDX_W = (2 * NW > 1) ? $clog2(2 * NW) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output reg_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);

   localparam int MAP_WORDS = 9 * NW;

   if (MAP_WORDS * 4 > (1 << ADDR_W)) begin : g_bad_map
      $error("ADDR_W too small for the register map");
   end

   int unsigned woff;
   int unsigned base;

   always_comb begin
      woff = 32'(addr[ADDR_W-1:2]);
      hit  = 1'b0;
      kind = RK_LEVEL;
      idx  = '0;
      base = 0;
      if (addr[1:0] == 2'b00) begin
         for (int t = 0; t < NUM_KINDS; t++) begin
            base = 32'(t * NW);
            if (woff >= base &&
                woff < base + 32'(words_for_kind(reg_kind_e'(3'(t)), NW))) begin
               hit  = 1'b1;
               kind = reg_kind_e'(3'(t));
               idx  = IDX_W'(woff - base);
            end
         end
      end
   end

endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic         ren_we,
   input  logic         fen_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] ren_q,
   output logic [W-1:0] fen_q,
   output logic [W-1:0] st_q
);

   logic [W-1:0] prev_q;
   logic [W-1:0] evt;
   logic [W-1:0] clr_mask;
   logic [W-1:0] st_d;

   always_comb begin
      evt      = (ren_q & cur & ~prev_q) | (fen_q & ~cur & prev_q);
      clr_mask = clr_we ? wdata : '0;
      st_d     = (st_q & ~clr_mask) | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         ren_q  <= '0;
         fen_q  <= '0;
         st_q   <= '0;
      end else begin
         prev_q <= cur;
         st_q   <= st_d;
         if (ren_we) ren_q <= wdata;
         if (fen_we) fen_q <= wdata;
      end
   end

   // R9: a pending bit survives any cycle in which it is not cleared
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != '0) |=>
         ((st_q & $past(st_q & ~clr_mask)) == $past(st_q & ~clr_mask)));

   // R9: a clearing write with no competing event leaves the written bits low
   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && evt == '0) |=> ((st_q & $past(wdata)) == '0));

   // R8: with no enable set, no status bit can newly appear
   p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ren_q | fen_q) == '0) |=> ((st_q & ~$past(st_q)) == '0));

   // R10: an edge that meets its own clear keeps the bit set
   p_coincide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && (evt & wdata) != '0) |=>
         ((st_q & $past(evt & wdata)) == $past(evt & wdata)));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NPINS  = 64,
   parameter int ADDR_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NPINS-1:0]     pin_in,
   output logic [NPINS-1:0]     pin_out,
   output logic [NPINS-1:0]     pin_oe,
   output logic [2*NPINS-1:0]   alt_sel,
   output logic                 irq
);

   localparam int NW    = NPINS / WORD_BITS;
   localparam int NA    = 2 * NW;
   localparam int IDX_W = (NA > 1) ? $clog2(NA) : 1;

   if ((NPINS % WORD_BITS) != 0 || NPINS < WORD_BITS) begin : g_bad_npins
      $error("NPINS must be a positive multiple of 32");
   end

   logic [NPINS-1:0] lvl_vec;
   logic [31:0]      lvl_w [NW];
   logic [31:0]      dir_w [NW];
   logic [31:0]      lat_w [NW];
   logic [31:0]      ren_w [NW];
   logic [31:0]      fen_w [NW];
   logic [31:0]      st_w  [NW];
   logic [31:0]      alt_w [NA];

   logic             hit;
   reg_kind_e        kind;
   logic [IDX_W-1:0] idx;
   logic             wr_go;
   logic             rd_go;
   logic [31:0]      rd_mux;
   logic [NW-1:0]    dir_we, set_we, clr_we, ren_we, fen_we, stc_we;
   logic [NA-1:0]    alt_we;

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_vec)
   );

   gpio_addr_dec #(.NW(NW), .ADDR_W(ADDR_W)) i_dec (
      .addr (bus_addr),
      .hit  (hit),
      .kind (kind),
      .idx  (idx)
   );

   assign wr_go = bus_en &  bus_we & hit;
   assign rd_go = bus_en & ~bus_we;

   for (genvar w = 0; w < NW; w++) begin : g_word
      logic sel;
      assign sel        = wr_go && (idx == IDX_W'(w));
      assign dir_we[w]  = sel && (kind == RK_DIR);
      assign set_we[w]  = sel && (kind == RK_SET);
      assign clr_we[w]  = sel && (kind == RK_CLR);
      assign ren_we[w]  = sel && (kind == RK_RISE);
      assign fen_we[w]  = sel && (kind == RK_FALL);
      assign stc_we[w]  = sel && (kind == RK_STAT);
      assign lvl_w[w]   = lvl_vec[w*WORD_BITS +: WORD_BITS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_w[w] <= '0;
            lat_w[w] <= '0;
         end else begin
            if (dir_we[w]) dir_w[w] <= bus_wdata;
            if (set_we[w])      lat_w[w] <= lat_w[w] | bus_wdata;
            else if (clr_we[w]) lat_w[w] <= lat_w[w] & ~bus_wdata;
         end
      end

      gpio_edge_word #(.W(WORD_BITS)) i_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .cur    (lvl_w[w]),
         .ren_we (ren_we[w]),
         .fen_we (fen_we[w]),
         .clr_we (stc_we[w]),
         .wdata  (bus_wdata),
         .ren_q  (ren_w[w]),
         .fen_q  (fen_w[w]),
         .st_q   (st_w[w])
      );

      assign pin_out[w*WORD_BITS +: WORD_BITS] = lat_w[w];
      assign pin_oe [w*WORD_BITS +: WORD_BITS] = dir_w[w];

      // R4: every written one appears on the latch
      p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set_we[w] |=> ((lat_w[w] & $past(bus_wdata)) == $past(bus_wdata)));

      // R4: zero bits of a set write keep their value
      p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set_we[w] |=> ((lat_w[w] & ~$past(bus_wdata)) ==
                        ($past(lat_w[w]) & ~$past(bus_wdata))));

      // R5: every written one drops on the latch
      p_clear_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
         clr_we[w] |=> ((lat_w[w] & $past(bus_wdata)) == '0));

      // R3: direction only moves on a direction write
      p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !dir_we[w] |=> $stable(dir_w[w]));
   end

   for (genvar a = 0; a < NA; a++) begin : g_alt
      assign alt_we[a] = wr_go && (kind == RK_ALT) && (idx == IDX_W'(a));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         alt_w[a] <= '0;
         else if (alt_we[a]) alt_w[a] <= bus_wdata;
      end

      assign alt_sel[a*WORD_BITS +: WORD_BITS] = alt_w[a];
   end

   always_comb begin
      rd_mux = '0;
      if (hit) begin
         for (int w = 0; w < NW; w++) begin
            if (idx == IDX_W'(w)) begin
               case (kind)
                  RK_LEVEL: rd_mux = lvl_w[w];
                  RK_DIR:   rd_mux = dir_w[w];
                  RK_SET,
                  RK_CLR:   rd_mux = lat_w[w];
                  RK_RISE:  rd_mux = ren_w[w];
                  RK_FALL:  rd_mux = fen_w[w];
                  RK_STAT:  rd_mux = st_w[w];
                  default:  ;
               endcase
            end
         end
         for (int a = 0; a < NA; a++) begin
            if (kind == RK_ALT && idx == IDX_W'(a)) rd_mux = alt_w[a];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_go) bus_rdata <= rd_mux;
   end

   always_comb begin
      irq = 1'b0;
      for (int w = 0; w < NW; w++) irq = irq | (|st_w[w]);
   end

   // R13: the interrupt starts low out of reset
   p_irq_reset_r13: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq);

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

   localparam int NPINS  = 64;
   localparam int ADDR_W = 8;
   localparam int NW     = NPINS / 32;
   localparam int MAPW   = 9 * NW;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 bus_en = 1'b0;
   logic                 bus_we = 1'b0;
   logic [ADDR_W-1:0]    bus_addr = '0;
   logic [31:0]          bus_wdata = '0;
   logic [31:0]          bus_rdata;
   logic [NPINS-1:0]     pin_in = '0;
   logic [NPINS-1:0]     pin_out;
   logic [NPINS-1:0]     pin_oe;
   logic [2*NPINS-1:0]   alt_sel;
   logic                 irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [NPINS-1:0]   m_dir = '0, m_lat = '0, m_ren = '0, m_fen = '0, m_st = '0;
   logic [2*NPINS-1:0] m_alt = '0;

   always #4 clk = ~clk;

   gpio_bank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_sel(alt_sel), .irq(irq)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input int woff);
      int k, w;
      if (woff >= MAPW) return 32'h0;
      if (woff >= 7 * NW) return m_alt[(woff - 7*NW)*32 +: 32];
      k = woff / NW;
      w = woff % NW;
      case (k)
         0: return pin_in[w*32 +: 32];
         1: return m_dir[w*32 +: 32];
         2, 3: return m_lat[w*32 +: 32];
         4: return m_ren[w*32 +: 32];
         5: return m_fen[w*32 +: 32];
         default: return m_st[w*32 +: 32];
      endcase
   endfunction

   function automatic void model_wr(input int woff, input logic [31:0] d);
      int k, w;
      if (woff >= MAPW) return;
      if (woff >= 7 * NW) begin
         m_alt[(woff - 7*NW)*32 +: 32] = d;
         return;
      end
      k = woff / NW;
      w = woff % NW;
      case (k)
         1: m_dir[w*32 +: 32] = d;
         2: m_lat[w*32 +: 32] = m_lat[w*32 +: 32] | d;
         3: m_lat[w*32 +: 32] = m_lat[w*32 +: 32] & ~d;
         4: m_ren[w*32 +: 32] = d;
         5: m_fen[w*32 +: 32] = d;
         6: m_st[w*32 +: 32]  = m_st[w*32 +: 32] & ~d;
         default: ;
      endcase
   endfunction

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      if (a[1:0] == 2'b00) model_wr(int'(a[ADDR_W-1:2]), d);
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wr_reg(input int k, input int w, input logic [31:0] d);
      bus_write(ADDR_W'((k*NW + w) * 4), d);
   endtask

   task automatic chk_reg(input string req, input int woff);
      logic [31:0] d;
      bus_read(ADDR_W'(woff * 4), d);
      chk(req, {96'h0, d}, {96'h0, exp_read(woff)});
   endtask

   task automatic set_pins(input logic [NPINS-1:0] nv);
      logic [NPINS-1:0] ov;
      @(negedge clk);
      ov = pin_in;
      pin_in = nv;
      m_st = m_st | (m_ren & nv & ~ov) | (m_fen & ~nv & ov);
      repeat (4) @(negedge clk);
   endtask

   task automatic chk_ports(input string req);
      chk({req, " pin_out"}, {64'h0, pin_out}, {64'h0, m_lat});
      chk({req, " pin_oe"},  {64'h0, pin_oe},  {64'h0, m_dir});
      chk({req, " alt_sel"}, alt_sel, m_alt);
      chk({req, " irq"},     {127'h0, irq},    {127'h0, |m_st});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [NPINS-1:0] pv;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state
      chk_ports("R13");
      for (int i = 0; i < MAPW; i++) chk_reg("R13 reg", i);

      // R3: direction
      wr_reg(1, 0, 32'hA5A5_0F0F);
      wr_reg(1, NW-1, 32'h8000_0001);
      chk_ports("R3");
      chk_reg("R3 readback", 1*NW + 0);

      // R4 / R5: set and clear
      wr_reg(2, 1, 32'h0000_FFFF);
      chk_ports("R4");
      wr_reg(3, 1, 32'h0000_00F0);
      chk_ports("R5");
      wr_reg(2, 1, 32'h0000_0000);
      chk_ports("R4 zero write");
      chk_reg("R4 set readback", 2*NW + 1);
      chk_reg("R4 clr readback", 3*NW + 1);

      // R2: level readback through the synchroniser
      set_pins({32'hDEAD_BEEF, 32'h1234_5678});
      chk_reg("R2 level w0", 0);
      chk_reg("R2 level w1", 1);
      // R1: writes to level, unmapped and misaligned addresses are ignored
      wr_reg(0, 0, 32'hFFFF_FFFF);
      bus_write(ADDR_W'(MAPW * 4), 32'hFFFF_FFFF);
      bus_write(ADDR_W'(4 * NW + 1), 32'hFFFF_FFFF);
      chk_ports("R1 ignored writes");
      chk_reg("R1 unmapped read", MAPW);
      chk_reg("R1 unmapped read high", 63);
      chk_reg("R1 dir intact", 1*NW + 0);
      set_pins('0);

      // R6 / R7 / R8: edge enables
      wr_reg(4, 0, 32'h0000_00FF);
      wr_reg(5, 0, 32'h0000_0FF0);
      set_pins(64'h0000_0000_0000_FF00);
      chk_reg("R6 rise only", 6*NW + 0);
      chk_ports("R12 irq set");
      set_pins(64'h0000_0000_0000_00FF);
      chk_reg("R7 fall and both", 6*NW + 0);
      set_pins(64'h0000_0000_0000_F000);
      chk_reg("R8 disabled edges", 6*NW + 0);
      chk_reg("R8 other word", 6*NW + 1);

      // R9: write one to clear
      wr_reg(6, 0, 32'h0000_000F);
      chk_reg("R9 partial clear", 6*NW + 0);
      wr_reg(6, 0, 32'hFFFF_FFFF);
      chk_reg("R9 full clear", 6*NW + 0);
      chk_ports("R12 irq clear");

      // R10: edge meets a clear of the same bit in the same cycle
      wr_reg(4, 0, 32'h0003_0000);
      set_pins(64'h0000_0000_0002_0000);
      @(negedge clk);
      pv = pin_in;
      pin_in[16] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(6*NW*4); bus_wdata = 32'h0003_0000;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      m_st[17] = 1'b0;
      m_st[16] = 1'b1;
      chk_reg("R10 coincident edge kept", 6*NW + 0);
      chk_ports("R10 irq");
      wr_reg(6, 0, 32'hFFFF_FFFF);

      // R11: alternate function fields
      wr_reg(7, 3, 32'h0000_0030);
      chk("R11 pin50 field", {126'h0, alt_sel[101:100]}, {126'h0, 2'b11});
      wr_reg(7, 0, 32'h8000_0001);
      chk("R11 pin0 field", {126'h0, alt_sel[1:0]}, 128'h1);
      chk("R11 pin15 field", {126'h0, alt_sel[31:30]}, 128'h2);
      chk_reg("R11 readback", 7*NW + 3);
      chk_ports("R11");

      // random phase
      for (int it = 0; it < 300; it++) begin
         int op, woff;
         op = $urandom_range(0, 3);
         woff = $urandom_range(0, MAPW + 1);
         case (op)
            0: bus_write(ADDR_W'(woff * 4), $urandom);
            1: set_pins({$urandom, $urandom});
            2: chk_reg("R1 R2 R6 R7 R9 random read", woff);
            default: if ($urandom_range(0, 1) == 1) wr_reg(6, $urandom_range(0, NW-1), $urandom);
                     else bus_write(ADDR_W'(woff * 4), $urandom);
         endcase
         chk_ports("R4 R5 R12 random");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule